// File: doc/BRIEF.md
# SDRAM Refresh Timer and Sequencer

This block keeps synchronous DRAM contents alive. A free-running divider gives one of seven tick rates. An 8-bit up-counter advances on each tick and is compared with a programmed constant. When the two are equal the counter returns to zero and a refresh becomes due. The block asks the bus arbiter for the bus, drives a one-cycle refresh command once it is granted, and then holds a busy flag. The busy flag keeps the arbiter from issuing anything until the row-cycle recovery time has passed.

Two mode bits pick between periodic refresh and low-power self-refresh. Setting the self-refresh bit makes the block take the bus and issue a single entry command, after which it holds the bus. Clearing the bit issues an exit command, followed by the same recovery window that follows an ordinary refresh. Software programs the block through a small register write port. Periodic refresh carries on while the system sleeps or is held in manual reset, and register writes are refused during those conditions.

Top module: `sdram_refresh_ctl`

## Requirements
- R1: The select register (address 2, bits 2:0) sets the tick rate. Value 0 stops the counter. Values 1 through 7 give one tick every 4, 16, 64, 256, 1024, 2048 and 4096 clocks. Consecutive refresh commands are spaced by (constant+1) times that divisor.
- R2: A write to the counter register (address 0) takes effect at the next clock edge. Once a non-zero select value is written, the counter climbs from the value it holds at that moment and is not forced to zero.
- R3: On each tick, a counter equal to the constant register (address 1) raises a refresh request and wraps the counter to zero. Any other value makes the counter increment.
- R4: Refresh request (refReq) stays high until gnt is sampled high. Further matches while a refresh is already pending produce no extra refresh command.
- R5: cmd carries 0 for idle, 1 for refresh, 2 for self-refresh entry and 3 for self-refresh exit. A refresh command lasts one cycle. It appears in the cycle after the edge where refReq and gnt are both high, and never without that grant.
- R6: busy is high for 1+A+B consecutive cycles, starting with the refresh command cycle. A and B are the two 3-bit fields of the timing register (address 4, bits 2:0 and 5:3). cmd stays idle for the rest of that window.
- R7: Mode register (address 3) bit 0 enables refresh and bit 1 selects self-refresh. Value 1 gives periodic refresh. Values 0 and 2 give no request at all. Value 3 requests the bus and, once granted, issues exactly one entry command. busy then stays high, and counter matches start no refresh.
- R8: Leaving self-refresh (mode back to 1) issues one exit command in the cycle after the write takes effect. Busy then covers 1+A+B cycles, counted from the exit command, after which periodic refresh resumes.
- R9: While sleepIn or manualRst is high, periodic refresh continues at the programmed spacing and register writes are ignored.
- R10: After rstN is released, cmd is idle, busy is low and refReq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset, clears all state |
| sleepIn | input | 1 | System sleep indication; blocks register writes |
| manualRst | input | 1 | Manual reset indication; blocks register writes, refresh continues |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select: 0 counter, 1 constant, 2 select, 3 mode, 4 timing |
| wrData | input | 8 | Register write data |
| gnt | input | 1 | Bus grant from the arbiter |
| refReq | output | 1 | Bus request for refresh or self-refresh entry |
| busy | output | 1 | Command lockout window; arbiter must not issue commands |
| cmd | output | 2 | Command to the memory: 0 idle, 1 refresh, 2 self-refresh entry, 3 exit |

## Verification
The bench sweeps every select value and several constants and compares refresh spacing with (constant+1) times the divisor. An off-by-one in the compare, or a wrong divisor entry, would shift every interval. It then runs all 64 pairs of the two recovery fields. A design that used only one field, or that ended the window a cycle early, would give a busy length other than 1+A+B. The bench also withholds the grant across several matches and then releases it. A design that queued each match would fire a second refresh at once. A start-value test with a bounded window shows whether the counter resumes from its written value or restarts at zero. The self-refresh round trip checks for a single entry command, for no refresh while the memory refreshes itself, and for the exit lockout.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_REF = 2'd1,
    CMD_SRE = 2'd2,
    CMD_SRX = 2'd3
  } refCmd_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadLock;
    logic decLock;
  } ctlStrobe_t;

  // status from the datapath to the control FSM
  typedef struct packed {
    logic match;
    logic autoMode;
    logic selfMode;
    logic lockZero;
    logic lockLast;
  } dpStatus_t;

  localparam logic [2:0] ADDR_COUNT  = 3'd0;
  localparam logic [2:0] ADDR_CONST  = 3'd1;
  localparam logic [2:0] ADDR_SELECT = 3'd2;
  localparam logic [2:0] ADDR_MODE   = 3'd3;
  localparam logic [2:0] ADDR_TIMING = 3'd4;

  // log2 of the clock divisor for each select code (0 means stopped)
  function automatic int divShift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 11;
      3'd7:    return 12;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import sdram_refresh_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 3,
  parameter int PRE_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             writeBlock,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  ctlStrobe_t       strobe,
  output dpStatus_t        status
);

  localparam int LOCK_W = TIME_W + 1;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  constQ;
  logic [2:0]        selQ;
  logic              refEnQ;
  logic              selfBitQ;
  logic [TIME_W-1:0] activeQ;
  logic [TIME_W-1:0] rowCycQ;
  logic [PRE_W-1:0]  divQ;
  logic [LOCK_W-1:0] lockQ;

  logic              wrOk;
  logic [PRE_W-1:0]  tickMask;
  logic              tick;
  logic              hit;
  logic [LOCK_W-1:0] lockSum;

  assign wrOk = wrEn & ~writeBlock;

  // prescaler: a free-running divider, tick when the selected low bits are all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divQ <= '0;
    else       divQ <= divQ + PRE_W'(1);
  end

  always_comb begin
    tickMask = PRE_W'((64'd1 << divShift(selQ)) - 64'd1);
  end

  assign tick    = (selQ != 3'd0) && ((divQ & tickMask) == tickMask);
  assign hit     = tick && (cntQ == constQ);
  assign lockSum = LOCK_W'(activeQ) + LOCK_W'(rowCycQ);

  // refresh interval counter; a software write has priority over a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (wrOk && wrAddr == ADDR_COUNT) begin
      cntQ <= wrData;
    end else if (tick) begin
      if (hit) cntQ <= '0;
      else     cntQ <= cntQ + CNT_W'(1);
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      constQ   <= '0;
      selQ     <= '0;
      refEnQ   <= 1'b0;
      selfBitQ <= 1'b0;
      activeQ  <= '0;
      rowCycQ  <= '0;
    end else if (wrOk) begin
      case (wrAddr)
        ADDR_CONST:  constQ <= wrData;
        ADDR_SELECT: selQ   <= wrData[2:0];
        ADDR_MODE: begin
          refEnQ   <= wrData[0];
          selfBitQ <= wrData[1];
        end
        ADDR_TIMING: begin
          activeQ <= wrData[TIME_W-1:0];
          rowCycQ <= wrData[2*TIME_W-1:TIME_W];
        end
        default: ;
      endcase
    end
  end

  // lockout down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (strobe.loadLock) begin
      lockQ <= lockSum;
    end else if (strobe.decLock && lockQ != '0) begin
      lockQ <= lockQ - LOCK_W'(1);
    end
  end

  always_comb begin
    status.match    = hit;
    status.autoMode = refEnQ & ~selfBitQ;
    status.selfMode = refEnQ & selfBitQ;
    status.lockZero = (lockSum == '0);
    status.lockLast = (lockQ == LOCK_W'(1));
  end

endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import sdram_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gnt,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       refReq,
  output logic       busy,
  output refCmd_e    cmd
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_LOCK,
    ST_SRE,
    ST_SELF,
    ST_SRX
  } state_e;

  state_e stateQ, stateD;
  logic   pendQ;
  logic   goRef;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    refReq = 1'b0;
    busy   = 1'b1;
    cmd    = CMD_NOP;
    goRef  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        busy   = 1'b0;
        refReq = status.selfMode | pendQ;
        if (gnt && status.selfMode) begin
          stateD = ST_SRE;
        end else if (gnt && pendQ) begin
          stateD = ST_REF;
          goRef  = 1'b1;
        end
      end
      ST_REF: begin
        cmd             = CMD_REF;
        strobe.loadLock = 1'b1;
        stateD          = status.lockZero ? ST_IDLE : ST_LOCK;
      end
      ST_LOCK: begin
        strobe.decLock = 1'b1;
        if (status.lockLast) stateD = ST_IDLE;
      end
      ST_SRE: begin
        cmd    = CMD_SRE;
        stateD = ST_SELF;
      end
      ST_SELF: begin
        if (!status.selfMode) stateD = ST_SRX;
      end
      ST_SRX: begin
        cmd             = CMD_SRX;
        strobe.loadLock = 1'b1;
        stateD          = status.lockZero ? ST_IDLE : ST_LOCK;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // one pending refresh at most; matches outside periodic mode are dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (!status.autoMode) begin
      pendQ <= 1'b0;
    end else if (goRef) begin
      pendQ <= status.match;
    end else if (status.match) begin
      pendQ <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_refresh_ctl.sv
module sdram_refresh_ctl
  import sdram_refresh_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 3,
  parameter int PRE_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepIn,
  input  logic             manualRst,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             gnt,
  output logic             refReq,
  output logic             busy,
  output logic [1:0]       cmd
);

  ctlStrobe_t strobe;
  dpStatus_t  status;
  refCmd_e    cmdE;
  logic       writeBlock;

  assign writeBlock = sleepIn | manualRst;

  refresh_datapath #(
    .CNT_W (CNT_W),
    .TIME_W(TIME_W),
    .PRE_W (PRE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .writeBlock(writeBlock),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .status    (status)
  );

  refresh_control u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .gnt   (gnt),
    .status(status),
    .strobe(strobe),
    .refReq(refReq),
    .busy  (busy),
    .cmd   (cmdE)
  );

  assign cmd = cmdE;

endmodule

// File: rtl/refresh_chk.sv
module refresh_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       gnt,
  input logic       refReq,
  input logic       busy,
  input logic [1:0] cmd
);

  AST_CMD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != 2'd0) |-> busy); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !gnt && !wrEn) |=> refReq); // R4

  AST_GNT_STARTS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && gnt) |=> (cmd == 2'd1 || cmd == 2'd2)); // R5

  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd1) |=> (cmd == 2'd0)); // R5

  AST_REF_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd1) |-> $past(refReq && gnt)); // R5

  AST_SRE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd2) |=> busy); // R7

endmodule

bind sdram_refresh_ctl refresh_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .gnt   (gnt),
  .refReq(refReq),
  .busy  (busy),
  .cmd   (cmd)
);

// File: tb/sdram_refresh_ctl_tb.sv
module sdram_refresh_ctl_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sleepIn;
  logic       manualRst;
  logic       wrEn;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  logic       gnt;
  logic       refReq;
  logic       busy;
  logic [1:0] cmd;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sdram_refresh_ctl u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .sleepIn  (sleepIn),
    .manualRst(manualRst),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .gnt      (gnt),
    .refReq   (refReq),
    .busy     (busy),
    .cmd      (cmd)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic checkRange(input string req, input int actual, input int lo, input int hi);
    checks++;
    if (actual < lo || actual > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, actual, lo, hi);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = a;
    wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // cycles until the next refresh command is visible
  task automatic waitRef(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cmd !== 2'd1 && n < 20000);
  endtask

  task automatic quiet();
    regWrite(3'd3, 8'd0);
    regWrite(3'd2, 8'd0);
    regWrite(3'd0, 8'd0);
  endtask

  function automatic int divOf(input int s);
    if (s <= 5) return 1 << (2 * s);
    if (s == 6) return 2048;
    return 4096;
  endfunction

  initial begin
    #(20 * 195000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int cnt;
    int cnt2;
    int cnt3;
    int bad;
    int consts[4];
    consts = '{0, 1, 3, 7};
    rstN = 1'b0; sleepIn = 1'b0; manualRst = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; gnt = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 cmd", int'(cmd), 0);
    check("R10 busy", int'(busy), 0);
    check("R10 refReq", int'(refReq), 0);

    // R1 R3 refresh spacing over select codes and constants
    for (int s = 1; s <= 3; s++) begin
      for (int k = 0; k < 4; k++) begin
        quiet();
        regWrite(3'd1, 8'(consts[k]));
        regWrite(3'd4, 8'd0);
        regWrite(3'd3, 8'd1);
        regWrite(3'd2, 8'(s));
        waitRef(n);
        waitRef(n);
        check("R1 R3 spacing", n, (consts[k] + 1) * divOf(s));
        waitRef(n);
        check("R1 R3 spacing repeat", n, (consts[k] + 1) * divOf(s));
      end
    end
    for (int s = 4; s <= 7; s++) begin
      quiet();
      regWrite(3'd1, 8'd0);
      regWrite(3'd3, 8'd1);
      regWrite(3'd2, 8'(s));
      waitRef(n);
      waitRef(n);
      check("R1 divisor", n, divOf(s));
    end

    // R1 select zero stops the counter
    quiet();
    regWrite(3'd1, 8'd0);
    regWrite(3'd3, 8'd1);
    cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (refReq === 1'b1 || cmd !== 2'd0) cnt++;
    end
    check("R1 stopped", cnt, 0);

    // R7 modes 0 and 2 give no request
    for (int m = 0; m <= 2; m += 2) begin
      quiet();
      regWrite(3'd1, 8'd0);
      regWrite(3'd3, 8'(m));
      regWrite(3'd2, 8'd1);
      cnt = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (refReq === 1'b1 || cmd !== 2'd0) cnt++;
      end
      check("R7 disabled mode", cnt, 0);
    end

    // R2 counting resumes from the written value
    quiet();
    regWrite(3'd0, 8'd5);
    regWrite(3'd1, 8'd8);
    regWrite(3'd4, 8'd0);
    regWrite(3'd3, 8'd1);
    regWrite(3'd2, 8'd1);
    waitRef(n);
    checkRange("R2 start value", n, 14, 17);

    // R4 request held without grant, later matches not queued
    quiet();
    regWrite(3'd1, 8'd7);
    regWrite(3'd4, 8'd0);
    regWrite(3'd3, 8'd1);
    gnt = 1'b0;
    regWrite(3'd2, 8'd2);
    n = 0;
    while (refReq !== 1'b1 && n < 500) begin
      @(negedge clk);
      n++;
    end
    cnt = 0; cnt2 = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (refReq !== 1'b1) cnt++;
      if (cmd === 2'd1) cnt2++;
    end
    check("R4 request held", cnt, 0);
    check("R5 no refresh without grant", cnt2, 0);
    @(negedge clk);
    gnt = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'd0;
    @(negedge clk);
    wrEn = 1'b0;
    cnt = (cmd === 2'd1) ? 1 : 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (cmd === 2'd1) cnt++;
    end
    check("R4 single refresh after release", cnt, 1);

    // R6 lockout length over every field pair
    quiet();
    regWrite(3'd1, 8'd15);
    regWrite(3'd3, 8'd1);
    regWrite(3'd2, 8'd1);
    bad = 0;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        regWrite(3'd4, 8'((b << 3) | a));
        waitRef(n);
        cnt = 0;
        while (busy === 1'b1 && cnt < 100) begin
          cnt++;
          if (cnt > 1 && cmd !== 2'd0) bad++;
          @(negedge clk);
        end
        check("R6 busy length", cnt, 1 + a + b);
      end
    end
    check("R6 no command in lockout", bad, 0);

    // R7 R8 self-refresh round trip
    quiet();
    regWrite(3'd1, 8'd3);
    regWrite(3'd4, 8'd26);
    regWrite(3'd3, 8'd1);
    regWrite(3'd2, 8'd1);
    gnt = 1'b0;
    regWrite(3'd3, 8'd3);
    repeat (20) @(negedge clk);
    check("R7 entry request", int'(refReq), 1);
    gnt = 1'b1;
    cnt = 0; cnt2 = 0; cnt3 = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cmd === 2'd2) cnt++;
      if (cmd === 2'd1) cnt2++;
      if (cmd === 2'd3) cnt3++;
    end
    check("R7 single entry", cnt, 1);
    check("R7 no refresh in self-refresh", cnt2, 0);
    check("R7 no exit while selected", cnt3, 0);
    check("R7 busy held", int'(busy), 1);
    regWrite(3'd3, 8'd1);
    n = 0;
    while (cmd !== 2'd3 && n < 10) begin
      @(negedge clk);
      n++;
    end
    check("R8 exit timing", n, 1);
    cnt = 0; bad = 0;
    while (busy === 1'b1 && cnt < 100) begin
      cnt++;
      if (cnt > 1 && cmd !== 2'd0) bad++;
      @(negedge clk);
    end
    check("R8 exit lockout", cnt, 6);
    check("R8 quiet lockout", bad, 0);
    waitRef(n);
    checkRange("R8 refresh resumes", n, 1, 20);

    // R9 sleep and manual reset keep refresh, block writes
    quiet();
    regWrite(3'd1, 8'd3);
    regWrite(3'd4, 8'd0);
    regWrite(3'd3, 8'd1);
    regWrite(3'd2, 8'd1);
    waitRef(n);
    sleepIn = 1'b1;
    regWrite(3'd1, 8'd0);
    waitRef(n);
    waitRef(n);
    check("R9 sleep spacing", n, 16);
    sleepIn = 1'b0;
    manualRst = 1'b1;
    regWrite(3'd1, 8'd0);
    waitRef(n);
    waitRef(n);
    check("R9 manual reset spacing", n, 16);
    manualRst = 1'b0;
    regWrite(3'd1, 8'd0);
    waitRef(n);
    waitRef(n);
    check("R9 writes restored", n, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule